// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and the calendar date in packed BCD. A one-second tick advances the seconds. A chain of carries then moves minutes, hours, day-of-week, day-of-month, month, the two-digit year and a century flag. Dividing down an oscillator and decoding a host bus are both left to the surrounding logic. The block only receives a single-cycle tick, a freeze level, a 12/24-hour select, and one write strobe per register. All write strobes share one data byte.

The freeze input lets a host read or load several registers without a carry slipping in between. One tick that arrives during a freeze is held and applied once the freeze drops, so the clock does not lose a second. Loading the seconds register restarts the second: any held tick is thrown away. The leap-year rule only tests whether the two-digit year is a multiple of four. A separate century flag flips each time the year wraps from 99 to 00.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: During reset (synchronous, active low) and until the first advance or write, the outputs read seconds 00, minutes 00, hour 00, day-of-week 0, day 01, month 01, year 00 and century 0.
- R2: Seconds and minutes count in BCD from 00 to 59. An advance at 59 gives 00 and carries one step into the next register; any other value goes up by one.
- R3: With the 12-hour select low, the hour is BCD 00 to 23. An advance at 23 gives 00 and carries into the date.
- R4: With the 12-hour select high, hour bit 5 is the PM marker and bits 4:0 hold BCD 01 to 12. The order is 12 AM, 01 AM … 11 AM, 12 PM (0x32), 01 PM … 11 PM (0x31), 12 AM (0x12). Only the step from 11 PM carries into the date.
- R5: Day-of-week is a 3-bit value that goes up by one on every date carry and wraps from 6 to 0.
- R6: The last day of each month is as follows. Months 04, 06, 09 and 11 end on 30. Month 02 ends on 29 when the year value is a multiple of four, and on 28 otherwise. All other months end on 31. A carry on the last day gives day 01 and carries into the month; on any other day it adds one.
- R7: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00, and that wrap flips the century flag.
- R8: While freeze is high, no register advances. A tick seen during freeze sets a single pending flag; further ticks in the same freeze are lost. In each cycle with freeze low, a pending tick or a new tick advances the chain by exactly one second. If both are present, one is kept pending for the next cycle.
- R9: A write strobe loads the shared data byte into its register at the next clock edge. This overrides any advance of that register in the same cycle. A carry arriving at a written register is dropped, and a written register sends no carry onward.
- R10: A write to the seconds register clears any pending held tick.
- R11: A month write loads data bits 4:0 as the month and data bit 7 as the century flag. The other registers take the low bits of the data byte: 7 for seconds and minutes, 6 for hour, 3 for day-of-week, 6 for day and 8 for year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| freeze | input | 1 | Hold all counters, keep one tick pending |
| mode_12h | input | 1 | 1 = 12-hour AM/PM hour format, 0 = 24-hour |
| wr_sec | input | 1 | Load seconds from wr_data |
| wr_min | input | 1 | Load minutes from wr_data |
| wr_hour | input | 1 | Load hour from wr_data |
| wr_dow | input | 1 | Load day-of-week from wr_data |
| wr_day | input | 1 | Load day-of-month from wr_data |
| wr_month | input | 1 | Load month and century flag from wr_data |
| wr_year | input | 1 | Load year from wr_data |
| wr_data | input | 8 | Shared write data byte |
| t_sec | output | 7 | Seconds, BCD |
| t_min | output | 7 | Minutes, BCD |
| t_hour | output | 6 | Hour, BCD (bit 5 = PM in 12-hour format) |
| t_dow | output | 3 | Day of week 0..6 |
| t_day | output | 6 | Day of month, BCD |
| t_month | output | 5 | Month, BCD |
| t_year | output | 8 | Two-digit year, BCD |
| t_century | output | 1 | Century flag |

## Verification
A host write and a counting advance can fall in the same cycle. The case that matters is a write landing in the cycle where a carry from below reaches the written register, or where the held tick is released. The bench provokes this by strobing a minute write on the tick that wraps the seconds. It also writes the seconds while a frozen tick is pending, and drops freeze in the same cycle as a fresh tick. A behavioural model applies the write-wins and carry-drop rules and is compared with every output on every clock. Directed checks confirm that the written value survives exactly, and that the held tick is either consumed or discarded.

// File: rtl/rtc_cal_pkg.sv
// Shared widths and BCD helpers for the time/calendar counter.
// Assumes every stored value is packed BCD written by a well-behaved host.
package rtc_cal_pkg;
    localparam int DATA_W = 8;
    localparam int SEC_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DOW_W  = 3;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 8;
    localparam int PM_BIT = 5;
    localparam int N_SEXA = 2;   // seconds and minutes share one cell design

    // Adds one to a two-digit BCD byte (no range check).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // True when a BCD year is a multiple of four.
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        else
            return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    endfunction

    // Last BCD day of a BCD month.
    function automatic logic [5:0] last_day(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_tick_hold.sv
// Freeze gate for the one-second tick. Produces at most one advance per
// cycle and remembers a single tick that arrived while frozen.
// Assumes the tick is a single-cycle pulse.
module rtc_tick_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    input  logic clr_pend,
    output logic adv,
    output logic pend
);
    // Advance when unfrozen and a tick is fresh or held.
    always_comb adv = !freeze && (tick || pend);

    // Pending flag: set by a frozen tick, consumed on release, cleared by a seconds write.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (clr_pend)  pend <= 1'b0;
        else if (freeze)    pend <= pend || tick;
        else                pend <= pend && tick;
    end

    a_r8_hold_tick: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && tick && !clr_pend |=> pend);
    a_r8_release_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze && !tick && pend && !clr_pend |=> !pend);
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend |=> !pend);
endmodule

// File: rtl/rtc_mod60.sv
// One BCD 00..59 counter cell with load, used for seconds and minutes.
// Assumes loaded values are valid BCD below 60.
module rtc_mod60 #(
    parameter int W = rtc_cal_pkg::SEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] val,
    output logic         carry
);
    import rtc_cal_pkg::*;
    localparam logic [W-1:0] LAST = W'(8'h59);

    logic [7:0] nxt;

    // Next count value: wrap at 59, else BCD increment.
    always_comb nxt = (val == LAST) ? 8'h00 : bcd_inc(8'(val));

    // Carry out only when a real increment wraps.
    always_comb carry = inc && !wr && (val == LAST);

    // Counter register with load priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    val <= '0;
        else if (wr)   val <= wr_val;
        else if (inc)  val <= nxt[W-1:0];
    end

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !wr && val == LAST |=> val == '0);
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> val == $past(wr_val));
endmodule

// File: rtl/rtc_time_chain.sv
// Seconds, minutes and hours. Emits a date carry at the end of each day.
// Assumes the host reloads the hour whenever it changes the hour format.
module rtc_time_chain (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               adv,
    input  logic                               mode_12h,
    input  logic                               wr_sec,
    input  logic                               wr_min,
    input  logic                               wr_hour,
    input  logic [rtc_cal_pkg::DATA_W-1:0]     wr_data,
    output logic [rtc_cal_pkg::SEC_W-1:0]      t_sec,
    output logic [rtc_cal_pkg::SEC_W-1:0]      t_min,
    output logic [rtc_cal_pkg::HOUR_W-1:0]     t_hour,
    output logic                               day_inc
);
    import rtc_cal_pkg::*;

    logic [N_SEXA-1:0] cell_inc, cell_wr, cell_carry;
    logic [SEC_W-1:0]  cell_val [N_SEXA];

    assign cell_wr  = {wr_min, wr_sec};
    assign cell_inc = {cell_carry[0], adv};

    // Seconds and minutes cells, chained by carry.
    for (genvar g = 0; g < N_SEXA; g++) begin : g_sexa
        rtc_mod60 #(.W(SEC_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (cell_inc[g]),
            .wr     (cell_wr[g]),
            .wr_val (wr_data[SEC_W-1:0]),
            .val    (cell_val[g]),
            .carry  (cell_carry[g])
        );
    end

    assign t_sec = cell_val[0];
    assign t_min = cell_val[1];

    logic              hour_inc, hour_end, pm;
    logic [4:0]        hr12;
    logic [7:0]        inc24, inc12;
    logic [HOUR_W-1:0] hour_nxt;

    assign hour_inc = cell_carry[1];
    assign pm       = t_hour[PM_BIT];
    assign hr12     = t_hour[4:0];

    // Next hour in either format.
    always_comb begin
        inc24 = bcd_inc({2'b00, t_hour});
        inc12 = bcd_inc({3'b000, hr12});
        if (mode_12h) begin
            if (hr12 == 5'h12)       hour_nxt = {pm, 5'h01};
            else if (hr12 == 5'h11)  hour_nxt = {!pm, 5'h12};
            else                     hour_nxt = {pm, inc12[4:0]};
            hour_end = (t_hour == 6'h31);
        end else begin
            hour_nxt = (t_hour == 6'h23) ? 6'h00 : inc24[HOUR_W-1:0];
            hour_end = (t_hour == 6'h23);
        end
    end

    // Day carry leaves only from an unwritten hour at its last value.
    always_comb day_inc = hour_inc && !wr_hour && hour_end;

    // Hour register with load priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         t_hour <= '0;
        else if (wr_hour)   t_hour <= wr_data[HOUR_W-1:0];
        else if (hour_inc)  t_hour <= hour_nxt;
    end

    a_r3_midnight: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_12h && hour_inc && !wr_hour && t_hour == 6'h23 |=> t_hour == 6'h00);
    a_r4_noon: assert property (@(posedge clk) disable iff (!rst_n)
        mode_12h && hour_inc && !wr_hour && t_hour == 6'h11 |=> t_hour == 6'h32);
    a_r4_one_pm: assert property (@(posedge clk) disable iff (!rst_n)
        mode_12h && hour_inc && !wr_hour && t_hour == 6'h32 |=> t_hour == 6'h21);
endmodule

// File: rtl/rtc_date_chain.sv
// Day-of-week, day, month, year and century flag, advanced by the day carry.
// Assumes loaded values are valid BCD within each field's range.
module rtc_date_chain (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            day_inc,
    input  logic                            wr_dow,
    input  logic                            wr_day,
    input  logic                            wr_month,
    input  logic                            wr_year,
    input  logic [rtc_cal_pkg::DATA_W-1:0]  wr_data,
    output logic [rtc_cal_pkg::DOW_W-1:0]   t_dow,
    output logic [rtc_cal_pkg::DAY_W-1:0]   t_day,
    output logic [rtc_cal_pkg::MON_W-1:0]   t_month,
    output logic [rtc_cal_pkg::YEAR_W-1:0]  t_year,
    output logic                            t_century
);
    import rtc_cal_pkg::*;
    localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(6);

    logic             leap, month_inc, year_inc;
    logic [DAY_W-1:0] day_end;
    logic [7:0]       day_up, mon_up, year_up;

    // Month length and carry decisions.
    always_comb begin
        leap      = leap_year(t_year);
        day_end   = last_day(t_month, leap);
        day_up    = bcd_inc({2'b00, t_day});
        mon_up    = bcd_inc({3'b000, t_month});
        year_up   = bcd_inc(t_year);
        month_inc = day_inc && !wr_day && (t_day == day_end);
        year_inc  = month_inc && !wr_month && (t_month == 5'h12);
    end

    // Day-of-week register.
    always_ff @(posedge clk) begin
        if (!rst_n)        t_dow <= '0;
        else if (wr_dow)   t_dow <= wr_data[DOW_W-1:0];
        else if (day_inc)  t_dow <= (t_dow == DOW_LAST) ? '0 : t_dow + 1'b1;
    end

    // Day-of-month register.
    always_ff @(posedge clk) begin
        if (!rst_n)        t_day <= DAY_W'(1);
        else if (wr_day)   t_day <= wr_data[DAY_W-1:0];
        else if (day_inc)  t_day <= (t_day == day_end) ? DAY_W'(1) : day_up[DAY_W-1:0];
    end

    // Month register.
    always_ff @(posedge clk) begin
        if (!rst_n)          t_month <= MON_W'(1);
        else if (wr_month)   t_month <= wr_data[MON_W-1:0];
        else if (month_inc)  t_month <= (t_month == 5'h12) ? MON_W'(1) : mon_up[MON_W-1:0];
    end

    // Year register.
    always_ff @(posedge clk) begin
        if (!rst_n)         t_year <= '0;
        else if (wr_year)   t_year <= wr_data;
        else if (year_inc)  t_year <= (t_year == 8'h99) ? 8'h00 : year_up;
    end

    // Century flag: loaded with the month, flipped on year wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      t_century <= 1'b0;
        else if (wr_month)                               t_century <= wr_data[DATA_W-1];
        else if (year_inc && !wr_year && t_year == 8'h99) t_century <= !t_century;
    end

    a_r5_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        day_inc && !wr_dow && t_dow == DOW_LAST |=> t_dow == '0);
    a_r6_feb_common: assert property (@(posedge clk) disable iff (!rst_n)
        day_inc && !wr_day && !wr_month && t_month == 5'h02 && t_day == 6'h28 && !leap
        |=> t_day == 6'h01 && t_month == 5'h03);
    a_r7_century: assert property (@(posedge clk) disable iff (!rst_n)
        year_inc && !wr_year && !wr_month && t_year == 8'h99 |=> t_century != $past(t_century));
endmodule

// File: rtl/rtc_bcd_calendar.sv
// Top of the BCD time/calendar counter: tick gate, time chain, date chain.
// Assumes sec_tick is a single-cycle pulse and all writes carry valid BCD.
module rtc_bcd_calendar (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       freeze,
    input  logic       mode_12h,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hour,
    input  logic       wr_dow,
    input  logic       wr_day,
    input  logic       wr_month,
    input  logic       wr_year,
    input  logic [7:0] wr_data,
    output logic [6:0] t_sec,
    output logic [6:0] t_min,
    output logic [5:0] t_hour,
    output logic [2:0] t_dow,
    output logic [5:0] t_day,
    output logic [4:0] t_month,
    output logic [7:0] t_year,
    output logic       t_century
);
    logic adv, pend, day_inc;

    rtc_tick_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .freeze   (freeze),
        .clr_pend (wr_sec),
        .adv      (adv),
        .pend     (pend)
    );

    rtc_time_chain u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .mode_12h (mode_12h),
        .wr_sec   (wr_sec),
        .wr_min   (wr_min),
        .wr_hour  (wr_hour),
        .wr_data  (wr_data),
        .t_sec    (t_sec),
        .t_min    (t_min),
        .t_hour   (t_hour),
        .day_inc  (day_inc)
    );

    rtc_date_chain u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_inc   (day_inc),
        .wr_dow    (wr_dow),
        .wr_day    (wr_day),
        .wr_month  (wr_month),
        .wr_year   (wr_year),
        .wr_data   (wr_data),
        .t_dow     (t_dow),
        .t_day     (t_day),
        .t_month   (t_month),
        .t_year    (t_year),
        .t_century (t_century)
    );

    a_r8_frozen_sec: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && !wr_sec |=> $stable(t_sec));
    a_r8_frozen_date: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && !wr_day |=> $stable(t_day));
endmodule

// File: tb/sim_rtc_bcd_calendar.sv
// Bench: behavioural integer model compared with every output on every clock,
// plus directed checks with hand-computed constants.
module sim_rtc_bcd_calendar;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0, freeze = 1'b0, mode_12h = 1'b0;
    int   wsel = 0;
    logic [7:0] wdata = 8'h00;
    logic [6:0] t_sec, t_min;
    logic [5:0] t_hour, t_day;
    logic [2:0] t_dow;
    logic [4:0] t_month;
    logic [7:0] t_year;
    logic       t_century;

    always #10 clk = ~clk;   // 50 MHz

    rtc_bcd_calendar u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .freeze(freeze), .mode_12h(mode_12h),
        .wr_sec(wsel == 1), .wr_min(wsel == 2), .wr_hour(wsel == 3), .wr_dow(wsel == 4),
        .wr_day(wsel == 5), .wr_month(wsel == 6), .wr_year(wsel == 7), .wr_data(wdata),
        .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_dow(t_dow), .t_day(t_day),
        .t_month(t_month), .t_year(t_year), .t_century(t_century)
    );

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit started = 0, done = 0;

    // Model state (binary integers, hour kept as the raw register byte)
    int m_s, m_m, m_hr, m_w, m_d, m_mo, m_y, m_c;
    bit m_pend;

    function automatic int b2i(input int x); return (x >> 4) * 10 + (x & 15); endfunction
    function automatic int i2b(input int x); return ((x / 10) << 4) | (x % 10); endfunction
    function automatic int to24(input int raw, input bit m12);
        if (m12) return (b2i(raw & 31) % 12) + (((raw & 32) != 0) ? 12 : 0);
        return b2i(raw);
    endfunction
    function automatic int from24(input int h, input bit m12);
        int hr;
        if (!m12) return i2b(h);
        hr = h % 12;
        if (hr == 0) hr = 12;
        return ((h >= 12) ? 32 : 0) | i2b(hr);
    endfunction
    function automatic int mlen(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model update
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_s = 0; m_m = 0; m_hr = 0; m_w = 0; m_d = 1; m_mo = 1; m_y = 0; m_c = 0;
            m_pend = 0; started = 1;
        end else begin
            bit a, c;
            int h;
            a = !freeze && (sec_tick || m_pend);
            if (freeze) m_pend = m_pend || sec_tick;
            else        m_pend = m_pend && sec_tick;
            if (wsel == 1) m_pend = 0;
            c = a;
            if (wsel == 1) begin m_s = b2i(wdata & 127); c = 0; end
            else if (c) begin m_s = (m_s + 1) % 60; c = (m_s == 0); end
            if (wsel == 2) begin m_m = b2i(wdata & 127); c = 0; end
            else if (c) begin m_m = (m_m + 1) % 60; c = (m_m == 0); end
            if (wsel == 3) begin m_hr = wdata & 63; c = 0; end
            else if (c) begin
                h = (to24(m_hr, mode_12h) + 1) % 24;
                c = (h == 0);
                m_hr = from24(h, mode_12h);
            end
            if (wsel == 4) m_w = wdata & 7;
            else if (c) m_w = (m_w + 1) % 7;
            if (wsel == 5) begin m_d = b2i(wdata & 63); c = 0; end
            else if (c) begin
                if (m_d == mlen(m_mo, m_y)) m_d = 1;
                else begin m_d++; c = 0; end
            end
            if (wsel == 6) begin m_mo = b2i(wdata & 31); m_c = wdata[7]; c = 0; end
            else if (c) begin
                if (m_mo == 12) m_mo = 1;
                else begin m_mo++; c = 0; end
            end
            if (wsel == 7) m_y = b2i(wdata);
            else if (c) begin
                m_y = (m_y + 1) % 100;
                if (m_y == 0) m_c ^= 1;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk(t_sec == 7'(i2b(m_s)) && t_min == 7'(i2b(m_m)), "R2 sec/min",
                {t_min, 1'b0, t_sec}, {i2b(m_m), 8'h00} | i2b(m_s));
            chk(t_hour == 6'(m_hr), mode_12h ? "R4 hour" : "R3 hour", t_hour, m_hr);
            chk(t_dow == 3'(m_w), "R5 dow", t_dow, m_w);
            chk(t_day == 6'(i2b(m_d)), "R6 day", t_day, i2b(m_d));
            chk(t_month == 5'(i2b(m_mo)) && t_year == 8'(i2b(m_y)) && t_century == 1'(m_c),
                "R7 month/year/century", {t_century, t_month, t_year},
                (m_c << 13) | (i2b(m_mo) << 8) | i2b(m_y));
        end
    end

    task automatic step(input bit t, input bit f, input int sel, input logic [7:0] d);
        @(posedge clk); #2;
        sec_tick = t; freeze = f; wsel = sel; wdata = d;
    endtask
    task automatic settle();   // apply last step, then sample at the negedge
        step(0, 0, 0, 8'h00);
        @(negedge clk);
    endtask
    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        step(0, 0, 3, h); step(0, 0, 2, m); step(0, 0, 1, s);
    endtask
    task automatic set_date(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
        step(0, 0, 7, y); step(0, 0, 6, mo); step(0, 0, 5, d);
    endtask

    // Watchdog
    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk(t_sec == 0 && t_hour == 0 && t_day == 6'h01 && t_month == 5'h01 && t_year == 0 && !t_century,
            "R1 reset", {t_day, t_month}, {6'h01, 5'h01});

        // R3 R5 R6 R7: non-leap Feb 28 23:59:59, dow 6 -> Mar 01, dow 0
        set_date(8'h23, 8'h02, 8'h28); step(0, 0, 4, 8'h06); set_time(8'h23, 8'h59, 8'h59);
        step(1, 0, 0, 8'h00); settle();
        chk(t_day == 6'h01 && t_month == 5'h03, "R6 feb common year", {t_month, t_day}, {5'h03, 6'h01});
        chk(t_dow == 3'd0 && t_hour == 6'h00, "R5 dow wrap / R3 midnight", {t_dow, t_hour}, 0);

        // R6: leap year Feb 28 -> Feb 29
        set_date(8'h24, 8'h02, 8'h28); set_time(8'h23, 8'h59, 8'h59);
        step(1, 0, 0, 8'h00); settle();
        chk(t_day == 6'h29 && t_month == 5'h02, "R6 feb leap", {t_month, t_day}, {5'h02, 6'h29});

        // R6: April 30 -> May 01
        set_date(8'h24, 8'h04, 8'h30); set_time(8'h23, 8'h59, 8'h59);
        step(1, 0, 0, 8'h00); settle();
        chk(t_day == 6'h01 && t_month == 5'h05, "R6 april end", {t_month, t_day}, {5'h05, 6'h01});

        // R7 R11: Dec 31 99, century 0 -> Jan 01 00, century 1
        set_date(8'h99, 8'h12, 8'h31); set_time(8'h23, 8'h59, 8'h59);
        step(1, 0, 0, 8'h00); settle();
        chk(t_year == 8'h00 && t_century && t_month == 5'h01, "R7 year wrap century",
            {t_century, t_month, t_year}, {1'b1, 5'h01, 8'h00});
        // R11: month write carries century in bit 7
        step(0, 0, 6, 8'h87); settle();
        chk(t_month == 5'h07 && t_century, "R11 month/century load", {t_century, t_month}, {1'b1, 5'h07});

        // R4: 12-hour format, 11 AM -> 12 PM, 12 PM -> 1 PM, 11 PM -> 12 AM
        mode_12h = 1'b1;
        set_time(8'h11, 8'h59, 8'h59); step(1, 0, 0, 8'h00); settle();
        chk(t_hour == 6'h32, "R4 noon", t_hour, 6'h32);
        set_time(8'h32, 8'h59, 8'h59); step(1, 0, 0, 8'h00); settle();
        chk(t_hour == 6'h21, "R4 one pm", t_hour, 6'h21);
        set_date(8'h24, 8'h03, 8'h10);
        set_time(8'h31, 8'h59, 8'h59); step(1, 0, 0, 8'h00); settle();
        chk(t_hour == 6'h12 && t_day == 6'h11, "R4 midnight carry", {t_hour, t_day}, {6'h12, 6'h11});
        mode_12h = 1'b0;
        step(0, 0, 3, 8'h05);

        // R8: two frozen ticks give one second after release
        set_time(8'h05, 8'h00, 8'h10);
        step(1, 1, 0, 8'h00); step(1, 1, 0, 8'h00); step(0, 1, 0, 8'h00);
        @(negedge clk);
        chk(t_sec == 7'h10, "R8 frozen no advance", t_sec, 7'h10);
        settle(); @(negedge clk);
        chk(t_sec == 7'h11, "R8 one held tick", t_sec, 7'h11);

        // R8: release together with a new tick keeps one pending
        step(1, 1, 0, 8'h00); step(1, 0, 0, 8'h00); settle(); @(negedge clk);
        chk(t_sec == 7'h13, "R8 release with tick", t_sec, 7'h13);

        // R10: seconds write discards the held tick
        step(1, 1, 0, 8'h00); step(0, 1, 1, 8'h30); settle(); @(negedge clk);
        chk(t_sec == 7'h30, "R10 held tick dropped", t_sec, 7'h30);

        // R9: minute write in the cycle the seconds wrap wins, carry lost
        set_time(8'h05, 8'h20, 8'h59);
        step(1, 0, 2, 8'h07); settle();
        chk(t_sec == 7'h00 && t_min == 7'h07, "R9 write beats carry", {t_min, t_sec}, {7'h07, 7'h00});

        // Mixed random ticks and freezes across a year end
        set_date(8'h99, 8'h12, 8'h31); set_time(8'h23, 8'h58, 8'h00);
        for (int i = 0; i < 4000; i++)
            step(($urandom % 3) == 0, ($urandom % 5) == 0, 0, 8'h00);
        settle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule